// File: doc/BRIEF.md
# Preset-Distance Gray Pointer Ring Buffer

A 128-word circular buffer that bridges an input-clock write side and an output-clock read side without any full or empty handshake. Software sets where the read pointer starts by loading a Gray-coded value. The same load clears the write pointer. From then on the writer advances once for every valid input word. The reader advances at a fixed fraction of the output clock: one word every four cycles, or every two in the fast rate mode. The two clocks are assumed to be frequency-locked by circuitry outside the block.

Nothing stops the pointers from meeting. Instead, the block compares the write pointer, synchronised into the read domain, with the read pointer. When they are equal it raises a registered alarm and sets a sticky collision flag.

A read-side controller sequences the load. It has three states:
- `RD_IDLE`: the state after reset. No reads are made and no comparison is done.
- `RD_ARM`: a load has been accepted. The controller waits for the write side to acknowledge that it has cleared its pointer.
- `RD_RUN`: reads advance and collisions are checked.

Transitions:
- `IDLE->ARM` on a good load.
- `ARM->RUN` when the clear acknowledge returns.
- `RUN->ARM` and `ARM->ARM` on any further good load.

A load with an odd number of ones is refused.

Top module: `gray_ring_buffer`

## Requirements
- R1: After reset, `alarm_o`, `alarm_sticky_o`, `load_err_o` and `rd_valid_o` are all 0.
- R2: A load whose 7-bit Gray word has an even number of 1 bits is accepted. On the next cycle `load_err_o` is 0 and `alarm_sticky_o` is 0.
- R3: A load whose Gray word has an odd number of 1 bits is refused. On the next cycle `load_err_o` is 1. The read pointer, the write pointer, the controller state and the sticky flag are left unchanged.
- R4: After an accepted load of Gray word G, reads begin at the binary address of G and step upward by one, wrapping at 128. The write pointer restarts at address 0.
- R5: With `rate_2x_i` = 0 and `rd_en_i` held at 1 in the run state, `rd_valid_o` pulses once every 4 read-clock cycles. Each pulse carries the word at the current read address.
- R6: With `rate_2x_i` = 1, `rd_valid_o` pulses once every 2 read-clock cycles.
- R7: While `rd_en_i` is 0 the read pointer holds, and on the following cycle `rd_valid_o` is 0.
- R8: In the run state, equality of the synchronised write pointer and the read pointer drives `alarm_o` high one cycle later. Whenever `alarm_o` is 1, `alarm_sticky_o` is also 1.
- R9: `alarm_sticky_o` stays at 1 until an accepted load clears it.
- R10: Before the first accepted load no read is performed and no alarm is raised, whatever the state of `rd_en_i`.
- R11: A write-clock cycle with `wr_valid_i` = 0 stores nothing and does not advance the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Input (write) clock |
| rd_clk | input | 1 | Output (read) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Store `wr_data_i` and advance the write pointer |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Allows the read divider to run |
| rate_2x_i | input | 1 | 1: read every 2 cycles, 0: every 4 |
| load_i | input | 1 | Strobe for a pointer preset (read domain) |
| load_gray_i | input | ADDR_W | Gray-coded start address for the read pointer |
| rd_data_o | output | DATA_W | Word read out |
| rd_valid_o | output | 1 | One-cycle pulse marking a new `rd_data_o` |
| alarm_o | output | 1 | Pointers equal (registered, read domain) |
| alarm_sticky_o | output | 1 | Collision seen since last accepted load |
| load_err_o | output | 1 | Last load was refused for odd parity |

## Verification
The bench walks a sequence of presets with mixed parity, including the all-zero word. The all-zero preset makes the pointers coincide immediately, so a design that mis-parities a word, or lets a refused load clear the sticky flag, shows a wrong error or sticky value. A streaming pass writes with idle gaps, reads from a high preset address across the wrap, and slips in an odd-parity load mid-stream. A design that advanced on idle writes, honoured the refused load, or started at the wrong address would return misordered data. The same pass checks that the alarm fires on exactly the read that reaches the stalled writer. Further checks measure the read cadence in both rate modes and confirm silence with the read enable low and before any preset.

// File: rtl/ringbuf_pkg.sv
package ringbuf_pkg;
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_ARM  = 2'd1,
        RD_RUN  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/gray_to_bin.sv
module gray_to_bin #(
    parameter int W = 7
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin_o[i] = ^gray_i[W-1:i];
    end
endmodule

// File: rtl/ring_mem.sv
module ring_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_en) begin
            rd_data <= cells[rd_addr];
        end
    end
endmodule

// File: rtl/ring_wr_side.sv
module ring_wr_side #(
    parameter int ADDR_W = 7
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              clr_req_tgl,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] wr_gray,
    output logic              clr_ack_tgl
);
    // stage 0 and 1 synchronise, stage 2 remembers the previous level
    logic [2:0]        req_pipe;
    logic              clr_now;
    logic [ADDR_W-1:0] addr_inc;

    assign clr_now     = req_pipe[1] ^ req_pipe[2];
    assign clr_ack_tgl = req_pipe[2];
    assign addr_inc    = wr_addr + ADDR_W'(1);
    assign wr_en       = wr_valid & ~clr_now;

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_pipe <= '0;
        end else begin
            req_pipe <= {req_pipe[1:0], clr_req_tgl};
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_gray <= '0;
        end else if (clr_now) begin
            wr_addr <= '0;
            wr_gray <= '0;
        end else if (wr_valid) begin
            wr_addr <= addr_inc;
            wr_gray <= addr_inc ^ (addr_inc >> 1);
        end
    end
endmodule

// File: rtl/ring_rd_ctrl.sv
module ring_rd_ctrl
    import ringbuf_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int SLOW_DIV  = 4,
    parameter int FAST_DIV  = 2
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rate_2x,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_gray,
    input  logic              clr_ack_tgl,
    output logic              clr_req_tgl,
    output logic              rd_tick,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] rd_gray,
    output logic              cmp_en,
    output logic              load_ok,
    output logic              rd_valid,
    output logic              load_err
);
    localparam int CNT_W = $clog2(SLOW_DIV);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);

    rd_state_e         state_q, state_d;
    logic [1:0]        ack_sync;
    logic [CNT_W-1:0]  div_cnt;
    logic [CNT_W-1:0]  div_last;
    logic [ADDR_W-1:0] load_bin;
    logic [ADDR_W-1:0] addr_inc;
    logic              load_bad;
    logic              ack_back;
    logic              in_run;

    gray_to_bin #(.W(ADDR_W)) u_g2b (
        .gray_i (load_gray),
        .bin_o  (load_bin)
    );

    assign load_ok  = load & ~(^load_gray);
    assign load_bad = load & (^load_gray);
    assign ack_back = (ack_sync[1] == clr_req_tgl);
    assign div_last = rate_2x ? FAST_LAST : SLOW_LAST;
    assign addr_inc = rd_addr + ADDR_W'(1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (load_ok) state_d = RD_ARM;
            RD_ARM: begin
                if (load_ok)       state_d = RD_ARM;
                else if (ack_back) state_d = RD_RUN;
            end
            RD_RUN:  if (load_ok) state_d = RD_ARM;
            default: state_d = RD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // state-derived outputs
    always_comb begin
        in_run = 1'b0;
        unique case (state_q)
            RD_IDLE: in_run = 1'b0;
            RD_ARM:  in_run = 1'b0;
            RD_RUN:  in_run = 1'b1;
            default: in_run = 1'b0;
        endcase
        cmp_en  = in_run;
        rd_tick = in_run & rd_en & (div_cnt >= div_last);
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_sync    <= '0;
            clr_req_tgl <= 1'b0;
        end else begin
            ack_sync <= {ack_sync[0], clr_ack_tgl};
            if (load_ok) clr_req_tgl <= ~clr_req_tgl;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (load_ok || !in_run) begin
            div_cnt <= '0;
        end else if (rd_en) begin
            div_cnt <= rd_tick ? '0 : div_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr <= '0;
            rd_gray <= '0;
        end else if (load_ok) begin
            rd_addr <= load_bin;
            rd_gray <= load_gray;
        end else if (rd_tick) begin
            rd_addr <= addr_inc;
            rd_gray <= addr_inc ^ (addr_inc >> 1);
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            load_err <= 1'b0;
        end else begin
            rd_valid <= rd_tick;
            if (load_bad)     load_err <= 1'b1;
            else if (load_ok) load_err <= 1'b0;
        end
    end
endmodule

// File: rtl/ring_collide.sv
module ring_collide #(
    parameter int ADDR_W = 7
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_gray,
    input  logic [ADDR_W-1:0] rd_gray,
    input  logic              cmp_en,
    input  logic              clr,
    output logic              alarm,
    output logic              sticky
);
    logic [ADDR_W-1:0] wg_s1, wg_s2;
    logic              hit;

    assign hit = cmp_en & ~clr & (wg_s2 == rd_gray);

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            wg_s1 <= '0;
            wg_s2 <= '0;
        end else begin
            wg_s1 <= wr_gray;
            wg_s2 <= wg_s1;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm  <= 1'b0;
            sticky <= 1'b0;
        end else begin
            alarm <= hit;
            if (clr)      sticky <= 1'b0;
            else if (hit) sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/gray_ring_buffer.sv
module gray_ring_buffer #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 7,
    parameter int SLOW_DIV = 4,
    parameter int FAST_DIV = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic              rate_2x_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_gray_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              alarm_o,
    output logic              alarm_sticky_o,
    output logic              load_err_o
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, wr_gray;
    logic [ADDR_W-1:0] rd_addr, rd_gray;
    logic              clr_req_tgl, clr_ack_tgl;
    logic              rd_tick, cmp_en, load_ok;

    ring_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .wr_clk      (wr_clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid_i),
        .clr_req_tgl (clr_req_tgl),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_gray     (wr_gray),
        .clr_ack_tgl (clr_ack_tgl)
    );

    ring_rd_ctrl #(
        .ADDR_W   (ADDR_W),
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV)
    ) u_rd (
        .rd_clk      (rd_clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en_i),
        .rate_2x     (rate_2x_i),
        .load        (load_i),
        .load_gray   (load_gray_i),
        .clr_ack_tgl (clr_ack_tgl),
        .clr_req_tgl (clr_req_tgl),
        .rd_tick     (rd_tick),
        .rd_addr     (rd_addr),
        .rd_gray     (rd_gray),
        .cmp_en      (cmp_en),
        .load_ok     (load_ok),
        .rd_valid    (rd_valid_o),
        .load_err    (load_err_o)
    );

    ring_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk  (wr_clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data_i),
        .rd_clk  (rd_clk),
        .rd_en   (rd_tick),
        .rd_addr (rd_addr),
        .rd_data (rd_data_o)
    );

    ring_collide #(.ADDR_W(ADDR_W)) u_col (
        .rd_clk  (rd_clk),
        .rst_n   (rst_n),
        .wr_gray (wr_gray),
        .rd_gray (rd_gray),
        .cmp_en  (cmp_en),
        .clr     (load_ok),
        .alarm   (alarm_o),
        .sticky  (alarm_sticky_o)
    );
endmodule

// File: rtl/gray_ring_buffer_chk.sv
module gray_ring_buffer_chk #(
    parameter int ADDR_W = 7
) (
    input logic              rd_clk,
    input logic              rst_n,
    input logic              rd_en_i,
    input logic              load_i,
    input logic [ADDR_W-1:0] load_gray_i,
    input logic              rd_valid_o,
    input logic              alarm_o,
    input logic              alarm_sticky_o,
    input logic              load_err_o
);
    // R8
    alarm_implies_sticky_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        alarm_o |-> alarm_sticky_o);

    // R9
    sticky_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (alarm_sticky_o && !load_i) |=> alarm_sticky_o);

    // R3
    odd_load_err_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (load_i && (^load_gray_i)) |=> load_err_o);

    // R2
    even_load_ok_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (load_i && !(^load_gray_i)) |=> (!load_err_o && !alarm_sticky_o));

    // R7
    rd_gate_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o);
endmodule

bind gray_ring_buffer gray_ring_buffer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .rd_clk         (rd_clk),
    .rst_n          (rst_n),
    .rd_en_i        (rd_en_i),
    .load_i         (load_i),
    .load_gray_i    (load_gray_i),
    .rd_valid_o     (rd_valid_o),
    .alarm_o        (alarm_o),
    .alarm_sticky_o (alarm_sticky_o),
    .load_err_o     (load_err_o)
);

// File: tb/gray_ring_buffer_tb.sv
module gray_ring_buffer_tb;
    localparam int DW = 8;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_valid_i;
    logic [DW-1:0] wr_data_i;
    logic          rd_en_i;
    logic          rate_2x_i;
    logic          load_i;
    logic [AW-1:0] load_gray_i;
    logic [DW-1:0] rd_data_o;
    logic          rd_valid_o;
    logic          alarm_o;
    logic          alarm_sticky_o;
    logic          load_err_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gray_ring_buffer u_dut (
        .wr_clk         (clk),
        .rd_clk         (clk),
        .rst_n          (rst_n),
        .wr_valid_i     (wr_valid_i),
        .wr_data_i      (wr_data_i),
        .rd_en_i        (rd_en_i),
        .rate_2x_i      (rate_2x_i),
        .load_i         (load_i),
        .load_gray_i    (load_gray_i),
        .rd_data_o      (rd_data_o),
        .rd_valid_o     (rd_valid_o),
        .alarm_o        (alarm_o),
        .alarm_sticky_o (alarm_sticky_o),
        .load_err_o     (load_err_o)
    );

    // {gray word, expected load_err, expected sticky}
    localparam logic [8:0] LOAD_TBL [8] = '{
        {7'h00, 1'b0, 1'b1},
        {7'h01, 1'b1, 1'b1},
        {7'h03, 1'b0, 1'b0},
        {7'h07, 1'b1, 1'b0},
        {7'h7F, 1'b1, 1'b0},
        {7'h44, 1'b0, 1'b0},
        {7'h55, 1'b0, 1'b0},
        {7'h40, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [AW-1:0] g);
        @(negedge clk);
        load_i      = 1'b1;
        load_gray_i = g;
        @(negedge clk);
        load_i      = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        int nval;
        int last_cyc;
        int alarm_at;
        int good;
        bit sent;

        rst_n = 1'b0; wr_valid_i = 1'b0; wr_data_i = '0; rd_en_i = 1'b0;
        rate_2x_i = 1'b0; load_i = 1'b0; load_gray_i = '0;
        wait_cyc(3);
        // R1 reset state
        chk("R1 alarm", int'(alarm_o), 0);
        chk("R1 sticky", int'(alarm_sticky_o), 0);
        chk("R1 load_err", int'(load_err_o), 0);
        chk("R1 rd_valid", int'(rd_valid_o), 0);
        rst_n = 1'b1;

        // R10: no reads or alarms before a preset
        rd_en_i = 1'b1;
        cnt = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (rd_valid_o || alarm_o) cnt++;
        end
        chk("R10 activity before preset", cnt, 0);
        rd_en_i = 1'b0;

        // vector table: R2 / R3 parity, R8 / R9 sticky behaviour
        for (int i = 0; i < 8; i++) begin
            do_load(LOAD_TBL[i][8:2]);
            wait_cyc(12);
            chk(LOAD_TBL[i][1] ? "R3 load_err" : "R2 load_err",
                int'(load_err_o), int'(LOAD_TBL[i][1]));
            chk("R9 sticky after preset", int'(alarm_sticky_o), int'(LOAD_TBL[i][0]));
        end

        // streaming pass: preset gray 0x44 = address 120
        do_load(7'h44);
        wait_cyc(12);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            wr_valid_i = 1'b1; wr_data_i = DW'(8'hA0 + i);
            @(negedge clk);
            wr_valid_i = 1'b0; wr_data_i = 8'hFF;   // R11: must be ignored
        end
        wait_cyc(5);
        rd_en_i = 1'b1; rate_2x_i = 1'b0;
        nval = 0; last_cyc = 0; alarm_at = -1; good = 0; sent = 1'b0;
        for (int c = 0; c < 400 && nval < 26; c++) begin
            @(negedge clk);
            load_i = 1'b0;
            if (alarm_o && alarm_at < 0) alarm_at = nval;
            if (rd_valid_o) begin
                if (nval > 0) chk("R5 read spacing slow", c - last_cyc, 4);
                if (nval >= 8 && nval < 24) begin
                    chk("R4 read data", int'(rd_data_o), 8'hA0 + nval - 8);
                    if (rd_data_o == DW'(8'hA0 + nval - 8)) good++;
                end
                last_cyc = c;
                nval++;
            end
            if (nval == 12 && !sent) begin
                load_i = 1'b1; load_gray_i = 7'h01;   // odd parity, refused
                sent = 1'b1;
            end
        end
        rd_en_i = 1'b0;
        chk("R11 words stored in order", good, 16);
        chk("R3 mid-stream refused load flagged", int'(load_err_o), 1);
        chk("R8 alarm on reaching writer", alarm_at, 24);
        chk("R8 sticky after collision", int'(alarm_sticky_o), 1);

        // R6 fast rate
        do_load(7'h44);
        wait_cyc(12);
        chk("R9 sticky cleared by preset", int'(alarm_sticky_o), 0);
        chk("R2 load_err cleared", int'(load_err_o), 0);
        rd_en_i = 1'b1; rate_2x_i = 1'b1;
        nval = 0; last_cyc = 0;
        for (int c = 0; c < 100 && nval < 6; c++) begin
            @(negedge clk);
            if (rd_valid_o) begin
                if (nval > 0) chk("R6 read spacing fast", c - last_cyc, 2);
                last_cyc = c;
                nval++;
            end
        end

        // R7 read enable low
        rd_en_i = 1'b0;
        wait_cyc(2);
        cnt = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (rd_valid_o) cnt++;
        end
        chk("R7 reads with enable low", cnt, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule